// File: doc/BRIEF.md
# Stack processor interrupt sequencer

This block is the control core of a small stack machine. The machine has no accumulator and no register file. Every load, store and I/O transfer moves through a single operand stack. The block steps through fetch and execute states and owns the program counter and a single return register. For each instruction it issues push and pop strobes to the stack, read and write strobes to memory, and read and write strobes to a separate port-mapped I/O space. Both address spaces share one address bus and one 16-bit read bus. Stack storage, memory and peripherals sit outside the block.

A level-sensitive interrupt request is accepted only when an instruction has finished. Two dedicated states then run in sequence. The first copies the program counter into the return register and the second loads the fixed handler address. CALL uses the same return register, and RET jumps back through it and drops the in-service flag. While that flag is set, further requests are ignored. After a return, at least one instruction runs before the next interrupt is taken. The run and continue inputs start the machine from idle: run begins again at address zero and continue keeps the current program counter. The halt input, or a HALT instruction, parks the machine in idle at an instruction boundary.

Top module: `stk_irq_seq`

## Requirements
- R1: While reset is asserted, the state is idle (0), the program counter and return register read zero, the in-service flag is low and every strobe is low.
- R2: From idle, run clears the program counter and starts fetching from address 0. Continue starts fetching at the held program counter. With neither input asserted the machine stays idle, and an interrupt request has no effect there.
- R3: A fetch drives the program counter onto the address bus with a memory read in the first fetch state. The second fetch state latches the word and increments the program counter, wrapping from 0xFFF to 0x000.
- R4: The opcode occupies bits 15:12 and the operand bits 11:0, using 0=HALT, 1=PUSHI, 2=LOAD, 3=STORE, 4=JMP, 5=JZ, 6=IN, 7=OUT, 8=CALL, 9=RET. Opcodes 0xA to 0xF have no effect beyond advancing the program counter.
- R5: PUSHI pushes the zero-extended operand. LOAD reads memory at the operand address and pushes the returned word one cycle later. STORE pops the stack top and writes it to memory at the operand address.
- R6: IN reads the I/O port at the operand address and pushes the returned word one cycle later. OUT pops the stack top and writes it to that port. I/O strobes occur only in the first execute state.
- R7: JMP loads the operand into the program counter. JZ pops the stack and branches to the operand only when the popped top is zero.
- R8: CALL copies the program counter (the address after the CALL) into the return register and jumps to the operand. RET loads the program counter from the return register and clears the in-service flag.
- R9: Halt asserted at an instruction boundary sends the machine to idle, and a HALT instruction does the same. Halt takes precedence over a pending interrupt. In idle the program counter is held.
- R10: An interrupt is entered only from an execute state at an instruction boundary. The first interrupt state saves the program counter into the return register and the second loads the handler address (default 0x800). Fetch then resumes there with the in-service flag set.
- R11: While the in-service flag is set, no interrupt is entered. After RET, the instruction at the return address executes before another interrupt is accepted.
- R12: The state output uses idle=000, fetch1=001, fetch2=010, exec1=011, exec2=100, int2=101 and int1=110, and each interrupt state lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Start from address zero when idle |
| halt_i | input | 1 | Stop at the next instruction boundary |
| cont_i | input | 1 | Resume from the held program counter when idle |
| irq_i | input | 1 | Level interrupt request |
| dbus_i | input | 16 | Read data from memory or I/O, one cycle after the read strobe |
| stk_top_i | input | 16 | Current stack top |
| abus_o | output | 12 | Address for memory or I/O |
| dbus_o | output | 16 | Write data (the stack top) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O port read strobe |
| io_wr_o | output | 1 | I/O port write strobe |
| stk_push_o | output | 1 | Push strobe |
| stk_pop_o | output | 1 | Pop strobe |
| stk_din_o | output | 16 | Value to push |
| pc_o | output | 12 | Program counter |
| rr_o | output | 12 | Return register |
| int_active_o | output | 1 | Interrupt in service |
| state_o | output | 3 | Sequencer state code |

## Verification
The bench holds the request high across a whole handler. A design that tests the request without the in-service flag would re-enter from inside the handler, and the logged push sequence would show extra handler values. Because the request is raised before the first fetch, an interrupt taken mid-instruction would put a handler push ahead of the first program push. A return that did not allow one instruction to run first would never execute the code at the return address. Other tests raise halt and interrupt together to expose a wrong priority, check that continue re-fetches from the held address rather than zero, and check that the program counter wraps at the top of the address space.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'b000,
    ST_FETCHA = 3'b001,
    ST_FETCHB = 3'b010,
    ST_EXECA  = 3'b011,
    ST_EXECB  = 3'b100,
    ST_INTB   = 3'b101,
    ST_INTA   = 3'b110
  } seq_state_e;

  typedef enum logic [2:0] {
    PC_HOLD, PC_ZERO, PC_INC, PC_OPD, PC_RR, PC_ISR
  } pc_cmd_e;

  localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_PUSHI = 4'h1;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OPC_JMP   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_JZ    = 4'h5;
  localparam logic [OPC_W-1:0] OPC_IN    = 4'h6;
  localparam logic [OPC_W-1:0] OPC_OUT   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_CALL  = 4'h8;
  localparam logic [OPC_W-1:0] OPC_RET   = 4'h9;

  typedef struct packed {
    logic halt;
    logic pushi;
    logic load;
    logic store;
    logic jmp;
    logic jz;
    logic inp;
    logic outp;
    logic call;
    logic ret;
    logic two_cyc;
  } dec_t;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = DW - OPC_W
) (
  input  logic [DW-1:0] ir,
  output dec_t          dec,
  output logic [AW-1:0] opd
);

  logic [OPC_W-1:0] opc;

  assign opc = ir[DW-1 -: OPC_W];
  assign opd = ir[AW-1:0];

  always_comb begin
    dec = '0;
    unique case (opc)
      OPC_HALT:  dec.halt  = 1'b1;
      OPC_PUSHI: dec.pushi = 1'b1;
      OPC_LOAD:  begin dec.load = 1'b1; dec.two_cyc = 1'b1; end
      OPC_STORE: dec.store = 1'b1;
      OPC_JMP:   dec.jmp   = 1'b1;
      OPC_JZ:    dec.jz    = 1'b1;
      OPC_IN:    begin dec.inp = 1'b1; dec.two_cyc = 1'b1; end
      OPC_OUT:   dec.outp  = 1'b1;
      OPC_CALL:  dec.call  = 1'b1;
      OPC_RET:   dec.ret   = 1'b1;
      default:   dec = '0;
    endcase
  end

endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
  import sirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       halt,
  input  logic       cont,
  input  logic       irq,
  input  logic       in_isr,
  input  logic       top_zero,
  input  dec_t       dec,
  output seq_state_e state_q,
  output pc_cmd_e    pc_cmd,
  output logic       rr_ld,
  output logic       isr_set,
  output logic       isr_clr,
  output logic       ir_ld,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       push,
  output logic       pop,
  output logic       din_bus
);

  seq_state_e state_d;
  logic       at_bnd;

  always_comb begin
    state_d = state_q;
    pc_cmd  = PC_HOLD;
    rr_ld   = 1'b0;
    isr_set = 1'b0;
    isr_clr = 1'b0;
    ir_ld   = 1'b0;
    mem_rd  = 1'b0;
    mem_wr  = 1'b0;
    io_rd   = 1'b0;
    io_wr   = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    din_bus = 1'b0;
    at_bnd  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run) begin
          state_d = ST_FETCHA;
          pc_cmd  = PC_ZERO;
        end else if (cont) begin
          state_d = ST_FETCHA;
        end
      end
      ST_FETCHA: begin
        mem_rd  = 1'b1;
        state_d = ST_FETCHB;
      end
      ST_FETCHB: begin
        ir_ld   = 1'b1;
        pc_cmd  = PC_INC;
        state_d = ST_EXECA;
      end
      ST_EXECA: begin
        if (dec.pushi) push = 1'b1;
        if (dec.load)  mem_rd = 1'b1;
        if (dec.store) begin pop = 1'b1; mem_wr = 1'b1; end
        if (dec.inp)   io_rd = 1'b1;
        if (dec.outp)  begin pop = 1'b1; io_wr = 1'b1; end
        if (dec.jmp)   pc_cmd = PC_OPD;
        if (dec.jz) begin
          pop = 1'b1;
          if (top_zero) pc_cmd = PC_OPD;
        end
        if (dec.call) begin rr_ld = 1'b1; pc_cmd = PC_OPD; end
        if (dec.ret)  begin isr_clr = 1'b1; pc_cmd = PC_RR; end
        if (dec.halt)         state_d = ST_IDLE;
        else if (dec.two_cyc) state_d = ST_EXECB;
        else                  at_bnd  = 1'b1;
      end
      ST_EXECB: begin
        push    = 1'b1;
        din_bus = 1'b1;
        at_bnd  = 1'b1;
      end
      ST_INTA: begin
        rr_ld   = 1'b1;
        isr_set = 1'b1;
        state_d = ST_INTB;
      end
      ST_INTB: begin
        pc_cmd  = PC_ISR;
        state_d = ST_FETCHA;
      end
      default: state_d = ST_IDLE;
    endcase
    if (at_bnd) begin
      if (halt)                state_d = ST_IDLE;
      else if (irq && !in_isr) state_d = ST_INTA;
      else                     state_d = ST_FETCHA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !run && !cont) |=> state_q == ST_IDLE);

  p_io_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> state_q == ST_EXECA);

  p_halt_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXECB && halt) |=> state_q == ST_IDLE);

endmodule

// File: rtl/sirq_pcrr.sv
module sirq_pcrr
  import sirq_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned ISR_ADDR = 'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pc_cmd_e       pc_cmd,
  input  logic          rr_ld,
  input  logic          isr_set,
  input  logic          isr_clr,
  input  logic [AW-1:0] opd,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] rr_q,
  output logic          isr_q
);

  localparam logic [AW-1:0] VEC_ADDR = AW'(ISR_ADDR);

  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q;
    unique case (pc_cmd)
      PC_ZERO: pc_d = '0;
      PC_INC:  pc_d = pc_q + AW'(1);
      PC_OPD:  pc_d = opd;
      PC_RR:   pc_d = rr_q;
      PC_ISR:  pc_d = VEC_ADDR;
      default: pc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_ld) rr_q <= pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        isr_q <= 1'b0;
    else if (isr_set)  isr_q <= 1'b1;
    else if (isr_clr)  isr_q <= 1'b0;
  end

  p_rr_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rr_ld |=> rr_q == $past(pc_q));

  p_ret_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr && !isr_set) |=> !isr_q);

endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned ISR_ADDR = 'h800,
  localparam int unsigned AW      = DW - OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          halt_i,
  input  logic          cont_i,
  input  logic          irq_i,
  input  logic [DW-1:0] dbus_i,
  input  logic [DW-1:0] stk_top_i,
  output logic [AW-1:0] abus_o,
  output logic [DW-1:0] dbus_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o,
  output logic          stk_push_o,
  output logic          stk_pop_o,
  output logic [DW-1:0] stk_din_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] rr_o,
  output logic          int_active_o,
  output logic [2:0]    state_o
);

  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [DW-1:0] ir_q;
  dec_t          dec;
  logic [AW-1:0] opd;
  seq_state_e    state_q;
  pc_cmd_e       pc_cmd;
  logic          rr_ld, isr_set, isr_clr, ir_ld, din_bus;
  logic [AW-1:0] pc_q, rr_q;
  logic          isr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   ir_q <= '0;
    else if (ir_ld) ir_q <= dbus_i;
  end

  sirq_decode #(.DW(DW)) u_dec (
    .ir  (ir_q),
    .dec (dec),
    .opd (opd)
  );

  sirq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (run_i),
    .halt     (halt_i),
    .cont     (cont_i),
    .irq      (irq_i),
    .in_isr   (isr_q),
    .top_zero (stk_top_i == '0),
    .dec      (dec),
    .state_q  (state_q),
    .pc_cmd   (pc_cmd),
    .rr_ld    (rr_ld),
    .isr_set  (isr_set),
    .isr_clr  (isr_clr),
    .ir_ld    (ir_ld),
    .mem_rd   (mem_rd_o),
    .mem_wr   (mem_wr_o),
    .io_rd    (io_rd_o),
    .io_wr    (io_wr_o),
    .push     (stk_push_o),
    .pop      (stk_pop_o),
    .din_bus  (din_bus)
  );

  sirq_pcrr #(.AW(AW), .ISR_ADDR(ISR_ADDR)) u_pcrr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .pc_cmd  (pc_cmd),
    .rr_ld   (rr_ld),
    .isr_set (isr_set),
    .isr_clr (isr_clr),
    .opd     (opd),
    .pc_q    (pc_q),
    .rr_q    (rr_q),
    .isr_q   (isr_q)
  );

  assign abus_o       = (state_q == ST_EXECA) ? opd : pc_q;
  assign dbus_o       = stk_top_i;
  assign stk_din_o    = din_bus ? dbus_i : {{OPC_W{1'b0}}, opd};
  assign pc_o         = pc_q;
  assign rr_o         = rr_q;
  assign int_active_o = isr_q;
  assign state_o      = state_q;

  p_inta_from_exec_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_INTA) |-> ($past(state_q) == ST_EXECA || $past(state_q) == ST_EXECB));

  p_int_pair_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_INTA) |=> state_q == ST_INTB);

  p_isr_entry_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_INTB) |=> (state_q == ST_FETCHA && pc_q == AW'(ISR_ADDR) && isr_q));

  p_no_nest_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    isr_q |=> state_q != ST_INTA);

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_FETCHB) |=> pc_q == $past(pc_q) + AW'(1));

endmodule

// File: tb/tb_stk_irq_seq.sv
module tb_stk_irq_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0, halt_i = 1'b0, cont_i = 1'b0, irq_i = 1'b0;
  logic [15:0] dbus_i, stk_top_i;
  logic [11:0] abus_o, pc_o, rr_o;
  logic [15:0] dbus_o, stk_din_o;
  logic        mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, stk_push_o, stk_pop_o;
  logic        int_active_o;
  logic [2:0]  state_o;

  always #10 clk = ~clk;

  stk_irq_seq dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .halt_i(halt_i), .cont_i(cont_i),
    .irq_i(irq_i), .dbus_i(dbus_i), .stk_top_i(stk_top_i), .abus_o(abus_o),
    .dbus_o(dbus_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .io_rd_o(io_rd_o),
    .io_wr_o(io_wr_o), .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o),
    .stk_din_o(stk_din_o), .pc_o(pc_o), .rr_o(rr_o), .int_active_o(int_active_o),
    .state_o(state_o)
  );

  // ---- stubs: memory (256 words, index {a[11],a[6:0]}), I/O, stack, monitor
  logic [15:0] mem [256];
  logic [15:0] mem_q, io_q;
  logic        src_io;
  logic [15:0] seed_top;
  logic        mon_clr = 1'b0;
  logic [15:0] stk [16];
  logic [4:0]  sp;
  int          n_push, n_pop, n_inta, nest_err, n_st6, n_st5;
  logic [15:0] last_din, last_wr;
  logic [15:0] plog [8];
  logic [11:0] isr_addr, isr_rr;
  logic [2:0]  prev_st;

  function automatic logic [7:0] idx(input logic [11:0] a);
    return {a[11], a[6:0]};
  endfunction

  assign dbus_i    = src_io ? io_q : mem_q;
  assign stk_top_i = (sp != 0) ? stk[sp - 5'd1] : seed_top;

  always @(posedge clk) begin
    if (mem_rd_o) begin mem_q <= mem[idx(abus_o)]; src_io <= 1'b0; end
    if (io_rd_o)  begin io_q <= {4'hA, abus_o}; src_io <= 1'b1; end
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      sp <= '0; n_push <= 0; n_pop <= 0; n_inta <= 0; nest_err <= 0;
      n_st6 <= 0; n_st5 <= 0; last_din <= '0; last_wr <= '0;
      isr_addr <= '0; isr_rr <= '0; prev_st <= state_o;
    end else begin
      if (stk_push_o) begin
        if (sp < 16) begin stk[sp[3:0]] <= stk_din_o; sp <= sp + 5'd1; end
        if (n_push < 8) plog[n_push[2:0]] <= stk_din_o;
        n_push <= n_push + 1;
        last_din <= stk_din_o;
      end
      if (stk_pop_o) begin
        if (sp != 0) sp <= sp - 5'd1;
        n_pop <= n_pop + 1;
      end
      if (mem_wr_o || io_wr_o) last_wr <= dbus_o;
      if (state_o == 3'b110) begin
        n_st6 <= n_st6 + 1;
        if (prev_st != 3'b110) n_inta <= n_inta + 1;
        if (int_active_o) nest_err <= nest_err + 1;
      end
      if (state_o == 3'b101) n_st5 <= n_st5 + 1;
      if (prev_st == 3'b101 && state_o == 3'b001) begin
        isr_addr <= abus_o; isr_rr <= rr_o;
      end
      prev_st <= state_o;
    end
  end

  // ---- checking
  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic pulse(input bit use_run);
    @(negedge clk);
    if (use_run) run_i = 1'b1; else cont_i = 1'b1;
    @(negedge clk);
    run_i = 1'b0; cont_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (state_o == 3'b000) break;
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h1, 4'h2, 4'h3: return "R5";
      4'h4, 4'h5:       return "R7";
      4'h6, 4'h7:       return "R6";
      4'h8, 4'h9:       return "R8";
      default:          return "R4";
    endcase
  endfunction

  // {instr, top, exp pc, pushes, pops, exp pushed value, exp written value}
  localparam int NV = 12;
  localparam logic [87:0] VEC [NV] = '{
    {16'h105A, 16'h0000, 16'h0002, 4'd1, 4'd0, 16'h005A, 16'h0000},
    {16'h2020, 16'h0000, 16'h0002, 4'd1, 4'd0, 16'h1234, 16'h0000},
    {16'h3030, 16'hBEEF, 16'h0002, 4'd0, 4'd1, 16'h0000, 16'hBEEF},
    {16'h4040, 16'h0000, 16'h0041, 4'd0, 4'd0, 16'h0000, 16'h0000},
    {16'h5050, 16'h0000, 16'h0051, 4'd0, 4'd1, 16'h0000, 16'h0000},
    {16'h5050, 16'h0007, 16'h0002, 4'd0, 4'd1, 16'h0000, 16'h0000},
    {16'h60C3, 16'h0000, 16'h0002, 4'd1, 4'd0, 16'hA0C3, 16'h0000},
    {16'h7011, 16'h5555, 16'h0002, 4'd0, 4'd1, 16'h0000, 16'h5555},
    {16'h8060, 16'h0000, 16'h0061, 4'd0, 4'd0, 16'h0000, 16'h0000},
    {16'h9000, 16'h0000, 16'h0002, 4'd0, 4'd0, 16'h0000, 16'h0000},
    {16'hF123, 16'h0000, 16'h0002, 4'd0, 4'd0, 16'h0000, 16'h0000},
    {16'h4FFF, 16'h0000, 16'h0000, 4'd0, 4'd0, 16'h0000, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] held;
    seed_top = 16'h0000;
    clr_mem();
    mem[8'h20] = 16'h1234;
    repeat (3) @(negedge clk);
    // R1 and R12: reset state
    chk("R1 state", {29'd0, state_o}, 32'h0);
    chk("R1 pc", {20'd0, pc_o}, 32'h0);
    chk("R1 rr", {20'd0, rr_o}, 32'h0);
    chk("R1 flag", {31'd0, int_active_o}, 32'h0);
    chk("R1 strobes", {26'd0, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, stk_push_o, stk_pop_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: idle holds with interrupt request present
    irq_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 idle ignores irq", {29'd0, state_o}, 32'h0);
    irq_i = 1'b0;

    // vector table: one instruction at 0, HALT everywhere else
    for (int v = 0; v < NV; v++) begin
      logic [87:0] e;
      e = VEC[v];
      mem[0] = e[87:72];
      seed_top = e[71:56];
      clr_mon();
      pulse(1'b1);
      wait_idle();
      chk({tag_of(e[87:84]), " pc"}, {20'd0, pc_o}, {20'd0, e[51:40]});
      chk({tag_of(e[87:84]), " pushes"}, n_push, {28'd0, e[39:36]});
      chk({tag_of(e[87:84]), " pops"}, n_pop, {28'd0, e[35:32]});
      chk({tag_of(e[87:84]), " pushed"}, {16'd0, last_din}, {16'd0, e[31:16]});
      chk({tag_of(e[87:84]), " written"}, {16'd0, last_wr}, {16'd0, e[15:0]});
      if (e[87:84] == 4'h8) chk("R8 call saves", {20'd0, rr_o}, 32'h1);
    end
    seed_top = 16'h0000;

    // R9 / R2: halt input, continue resumes, run restarts
    clr_mem();
    for (int i = 0; i < 8; i++) mem[i] = 16'hF000;
    clr_mon();
    pulse(1'b1);
    repeat (9) @(negedge clk);
    halt_i = 1'b1;
    wait_idle();
    halt_i = 1'b0;
    held = pc_o;
    chk("R9 halted mid-program", {31'd0, (held != 0 && held < 12'd9)}, 32'h1);
    irq_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 pc held in idle", {20'd0, pc_o}, {20'd0, held});
    chk("R2 stays idle", {29'd0, state_o}, 32'h0);
    irq_i = 1'b0;
    @(negedge clk) cont_i = 1'b1;
    @(negedge clk) cont_i = 1'b0;
    chk("R2 continue fetch addr", {20'd0, abus_o}, {20'd0, held});
    chk("R3 fetch strobe", {31'd0, mem_rd_o}, 32'h1);
    wait_idle();
    chk("R9 halt opcode", {20'd0, pc_o}, 32'h9);
    @(negedge clk) run_i = 1'b1;
    @(negedge clk) run_i = 1'b0;
    chk("R2 run fetch addr", {20'd0, abus_o}, 32'h0);
    wait_idle();

    // R9: halt wins over interrupt at the same boundary
    clr_mon();
    pulse(1'b1);
    repeat (5) @(negedge clk);
    halt_i = 1'b1; irq_i = 1'b1;
    wait_idle();
    halt_i = 1'b0; irq_i = 1'b0;
    chk("R9 halt over irq", n_inta, 0);

    // R10 / R11 / R12: interrupt held high through handlers
    clr_mem();
    mem[0] = 16'h1011; mem[1] = 16'h1022; mem[2] = 16'h0000;
    mem[8'h80] = 16'h10AA; mem[8'h81] = 16'h10BB; mem[8'h82] = 16'h9000;
    clr_mon();
    irq_i = 1'b1;
    pulse(1'b1);
    wait_idle();
    irq_i = 1'b0;
    chk("R10 boundary first", {16'd0, plog[0]}, 32'h0011);
    chk("R10 handler 1", {16'd0, plog[1]}, 32'h00AA);
    chk("R11 no reentry", {16'd0, plog[2]}, 32'h00BB);
    chk("R11 one after RET", {16'd0, plog[3]}, 32'h0022);
    chk("R11 second entry", {16'd0, plog[4]}, 32'h00AA);
    chk("R11 push total", n_push, 6);
    chk("R11 entries", n_inta, 2);
    chk("R11 nest", nest_err, 0);
    chk("R12 int1 cycles", n_st6, 2);
    chk("R12 int2 cycles", n_st5, 2);
    chk("R10 vector fetch", {20'd0, isr_addr}, 32'h800);
    chk("R10 saved pc", {20'd0, isr_rr}, 32'h2);
    chk("R8 ret pc", {20'd0, pc_o}, 32'h3);
    chk("R11 flag cleared", {31'd0, int_active_o}, 32'h0);

    // R1: reset in the middle of a handler
    clr_mon();
    irq_i = 1'b1;
    pulse(1'b1);
    for (int i = 0; i < 100; i++) begin
      if (int_active_o) break;
      @(negedge clk);
    end
    chk("R10 flag set", {31'd0, int_active_o}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset flag", {31'd0, int_active_o}, 32'h0);
    chk("R1 mid reset rr", {20'd0, rr_o}, 32'h0);
    chk("R1 mid reset state", {29'd0, state_o}, 32'h0);
    irq_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule